// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Burst Address Counters

This block is a true dual-port synchronous memory. Two fully independent ports, left and right, each have their own clock and can read or write any word at any time, including the same word in the same cycle. Each port captures its address, write data and controls on the rising edge of its own clock. Each port also owns an address counter: the counter can be loaded from the external address, cleared, advanced by one per clock, or held, so a port can stream through consecutive words after giving a single start address.

Every word is split into byte lanes with active-low lane selects. A port is selected only when its active-low first enable is low and its active-high second enable is high. Two devices can therefore share one address bus and be stacked in depth with no glue logic. Each port chooses flow-through or pipelined read latency with a static mode pin. Read data comes with a valid flag that replaces a high-impedance output. The depth is 2^ADDR_W words. The default ADDR_W is kept small so that the model stays small, and a 32K-word part uses ADDR_W = 15.

Top module: `dpram_burst_top`

## Requirements
- R1: The memory holds 2^ADDR_W words of 16 bits. Either port can write any word, and a word written by one port can be read by the other.
- R2: All request inputs are captured on the rising edge of the port's clock. With the mode pin low (flow-through), the read data and valid flag appear after the capturing edge and stay until the next edge.
- R3: With the mode pin high (pipelined), the read data and valid flag appear exactly one clock later than in flow-through mode.
- R4: The active-low lane selects cover two lanes: lane bit 1 selects data bits 15:8 and lane bit 0 selects bits 7:0. A write changes only the selected lanes. A read returns zero on every lane that is not selected.
- R5: A port is selected only when en_a_n is 0 and en_b is 1. Otherwise its writes are ignored and its valid flag stays low.
- R6: The internal address is updated on each clock by the first of these that applies: zero_n low clears it to 0; otherwise load_n low loads the external address; otherwise step_n low adds one; otherwise it is held.
- R7: Stepping from the all-ones address gives address 0.
- R8: The address load and the counter act whether or not the port is selected.
- R9: When one port writes a word in the same cycle that the other port reads it, the read returns the old contents. Reads from the next cycle onward return the new data.
- R10: The valid flag is high only for a selected read cycle (wr_n high) with out_en_n low. Read data is all zero whenever the flag is low.
- R11: A synchronous active-low reset clears both address counters and forces both ports to a deselected state with the valid flag low. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low reset, released in step with both clocks |
| l_clk | input | 1 | Left port clock |
| l_en_a_n | input | 1 | Left active-low enable |
| l_en_b | input | 1 | Left active-high enable |
| l_wr_n | input | 1 | Left write when 0, read when 1 |
| l_out_en_n | input | 1 | Left active-low output enable |
| l_lane_n | input | 2 | Left active-low lane selects (bit 1 = 15:8) |
| l_load_n | input | 1 | Left active-low address load |
| l_step_n | input | 1 | Left active-low counter advance |
| l_zero_n | input | 1 | Left active-low counter clear |
| l_pipe_mode | input | 1 | Left static latency select, 1 = pipelined |
| l_addr | input | ADDR_W | Left external address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data |
| l_rvalid | output | 1 | Left read data valid |
| r_clk | input | 1 | Right port clock |
| r_en_a_n | input | 1 | Right active-low enable |
| r_en_b | input | 1 | Right active-high enable |
| r_wr_n | input | 1 | Right write when 0, read when 1 |
| r_out_en_n | input | 1 | Right active-low output enable |
| r_lane_n | input | 2 | Right active-low lane selects (bit 1 = 15:8) |
| r_load_n | input | 1 | Right active-low address load |
| r_step_n | input | 1 | Right active-low counter advance |
| r_zero_n | input | 1 | Right active-low counter clear |
| r_pipe_mode | input | 1 | Right static latency select, 1 = pipelined |
| r_addr | input | ADDR_W | Right external address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data |
| r_rvalid | output | 1 | Right read data valid |

## Verification
The hardest case to reach from the ports is a same-cycle collision: one port writes a word in the very cycle the other port reads it, and the read is in pipelined mode, so the old value shows up one clock late. The bench drives both port clocks from one source. It first fills the word through the left port. It then issues a left write and a right read of that word in the same cycle, and holds the right read for one more cycle. This shows the old value and then the new one on successive pipelined outputs. The address load while the port is deselected is checked the same way: the load is made while deselected, and the first selected read that follows is expected to use that address.

// File: rtl/dpram_pkg.sv
// Package: shared constants and counter decode for the dual-port RAM.
// Assumes: lanes are bytes; counter controls are active low.
package dpram_pkg;
    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        CTR_ZERO,
        CTR_LOAD,
        CTR_STEP,
        CTR_HOLD
    } ctr_op_e;

    // Priority decode: clear beats load beats advance.
    function automatic ctr_op_e ctr_decode(input logic zero_n,
                                           input logic load_n,
                                           input logic step_n);
        ctr_op_e op;
        if (!zero_n)      op = CTR_ZERO;
        else if (!load_n) op = CTR_LOAD;
        else if (!step_n) op = CTR_STEP;
        else              op = CTR_HOLD;
        return op;
    endfunction
endpackage

// File: rtl/dpram_addr_ctr.sv
// Module: per-port internal address register with clear, load,
// advance and hold. Assumes: rst_n is synchronous to clk. The
// counter ignores the port selects on purpose.
module dpram_addr_ctr #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zero_n,
    input  logic              load_n,
    input  logic              step_n,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] addr_q
);
    import dpram_pkg::*;

    // Update the internal address by the control with the highest priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            case (ctr_decode(zero_n, load_n, step_n))
                CTR_ZERO: addr_q <= '0;
                CTR_LOAD: addr_q <= ext_addr;
                CTR_STEP: addr_q <= addr_q + 1'b1;
                default:  addr_q <= addr_q;
            endcase
        end
    end

    // R6
    ctr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_n |=> addr_q == '0);
    // R6
    ctr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_n && !load_n) |=> addr_q == $past(ext_addr));
    // R6
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_n && load_n && step_n) |=> $stable(addr_q));
    // R7
    ctr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_n && load_n && !step_n && addr_q == '1) |=> addr_q == '0);
endmodule

// File: rtl/dpram_bank.sv
// Module: one storage bank with a single masked write port and two
// combinational read ports. Assumes: only one clock writes a given
// bank. The two banks are combined by XOR in the top.
module dpram_bank #(
    parameter int ADDR_W = 11,
    parameter int LANES  = 2,
    localparam int DATA_W = LANES * dpram_pkg::LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  wmask,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    import dpram_pkg::*;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write only the lanes that the mask enables.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (wmask[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/dpram_port.sv
// Module: one port's request registers, address counter, select logic,
// lane masking and flow-through/pipelined output stage. Assumes:
// pipe_mode is static; rd_word is the memory word at acc_addr.
module dpram_port #(
    parameter int ADDR_W = 11,
    parameter int LANES  = 2,
    localparam int DATA_W = LANES * dpram_pkg::LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              wr_n,
    input  logic              out_en_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic              load_n,
    input  logic              step_n,
    input  logic              zero_n,
    input  logic              pipe_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              wr_en,
    output logic [LANES-1:0]  wr_mask,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    import dpram_pkg::*;

    logic              sel_q, wr_n_q, oe_n_q;
    logic [LANES-1:0]  lane_n_q;
    logic [DATA_W-1:0] wdata_q;
    logic              ft_valid, pv_q;
    logic [DATA_W-1:0] ft_data, pd_q;

    dpram_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_n   (zero_n),
        .load_n   (load_n),
        .step_n   (step_n),
        .ext_addr (addr),
        .addr_q   (acc_addr)
    );

    // Capture the request controls and write data on the port clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= 1'b0;
            wr_n_q   <= 1'b1;
            oe_n_q   <= 1'b1;
            lane_n_q <= '1;
            wdata_q  <= '0;
        end else begin
            sel_q    <= !en_a_n && en_b;
            wr_n_q   <= wr_n;
            oe_n_q   <= out_en_n;
            lane_n_q <= lane_n;
            wdata_q  <= wdata;
        end
    end

    assign wr_en    = sel_q && !wr_n_q;
    assign wr_mask  = ~lane_n_q;
    assign wr_data  = wdata_q;
    assign ft_valid = sel_q && wr_n_q && !oe_n_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign ft_data[g*LANE_W +: LANE_W] =
            (ft_valid && !lane_n_q[g]) ? rd_word[g*LANE_W +: LANE_W] : '0;

        // R4
        lane_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pipe_mode && lane_n[g]) |=> rdata[g*LANE_W +: LANE_W] == '0);
    end

    // Hold the flow-through result one more clock for pipelined mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_q <= 1'b0;
            pd_q <= '0;
        end else begin
            pv_q <= ft_valid;
            pd_q <= ft_data;
        end
    end

    assign rvalid = pipe_mode ? pv_q : ft_valid;
    assign rdata  = pipe_mode ? pd_q : ft_data;

    // R5
    desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!en_a_n && en_b) |=> !wr_en && (pipe_mode || !rvalid));
    // R3
    pipe_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && !(!en_a_n && en_b)) |=> ##1 !rvalid);
    // R10
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && (out_en_n || !wr_n)) |=> !rvalid);
    // R10
    zero_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> rdata == '0);
endmodule

// File: rtl/dpram_burst_top.sv
// Module: true dual-port RAM. Storage is two banks, one written by each
// port, and a word is the XOR of both banks. Each bank therefore has a
// single writer. Assumes: the two ports never write the same word in
// the same cycle, and rst_n is released in step with both clocks.
module dpram_burst_top #(
    parameter int ADDR_W = 11,
    parameter int LANES  = 2,
    localparam int DATA_W = LANES * dpram_pkg::LANE_W
) (
    input  logic              rst_n,
    input  logic              l_clk,
    input  logic              l_en_a_n,
    input  logic              l_en_b,
    input  logic              l_wr_n,
    input  logic              l_out_en_n,
    input  logic [LANES-1:0]  l_lane_n,
    input  logic              l_load_n,
    input  logic              l_step_n,
    input  logic              l_zero_n,
    input  logic              l_pipe_mode,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    input  logic              r_clk,
    input  logic              r_en_a_n,
    input  logic              r_en_b,
    input  logic              r_wr_n,
    input  logic              r_out_en_n,
    input  logic [LANES-1:0]  r_lane_n,
    input  logic              r_load_n,
    input  logic              r_step_n,
    input  logic              r_zero_n,
    input  logic              r_pipe_mode,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid
);
    logic [ADDR_W-1:0] l_acc, r_acc;
    logic              l_we, r_we;
    logic [LANES-1:0]  l_mask, r_mask;
    logic [DATA_W-1:0] l_wd, r_wd;
    logic [DATA_W-1:0] bl_at_l, bl_at_r, br_at_l, br_at_r;
    logic [DATA_W-1:0] l_word, r_word;

    assign l_word = bl_at_l ^ br_at_l;
    assign r_word = bl_at_r ^ br_at_r;

    dpram_port #(.ADDR_W(ADDR_W), .LANES(LANES)) u_port_l (
        .clk(l_clk), .rst_n(rst_n), .en_a_n(l_en_a_n), .en_b(l_en_b),
        .wr_n(l_wr_n), .out_en_n(l_out_en_n), .lane_n(l_lane_n),
        .load_n(l_load_n), .step_n(l_step_n), .zero_n(l_zero_n),
        .pipe_mode(l_pipe_mode), .addr(l_addr), .wdata(l_wdata),
        .rd_word(l_word), .acc_addr(l_acc), .wr_en(l_we), .wr_mask(l_mask),
        .wr_data(l_wd), .rdata(l_rdata), .rvalid(l_rvalid)
    );

    dpram_port #(.ADDR_W(ADDR_W), .LANES(LANES)) u_port_r (
        .clk(r_clk), .rst_n(rst_n), .en_a_n(r_en_a_n), .en_b(r_en_b),
        .wr_n(r_wr_n), .out_en_n(r_out_en_n), .lane_n(r_lane_n),
        .load_n(r_load_n), .step_n(r_step_n), .zero_n(r_zero_n),
        .pipe_mode(r_pipe_mode), .addr(r_addr), .wdata(r_wdata),
        .rd_word(r_word), .acc_addr(r_acc), .wr_en(r_we), .wr_mask(r_mask),
        .wr_data(r_wd), .rdata(r_rdata), .rvalid(r_rvalid)
    );

    // Left bank: stores left data XOR the right bank, so the XOR of both banks gives the word.
    dpram_bank #(.ADDR_W(ADDR_W), .LANES(LANES)) u_bank_l (
        .clk(l_clk), .we(l_we), .wmask(l_mask), .waddr(l_acc),
        .wdata(l_wd ^ br_at_l), .raddr_a(l_acc), .raddr_b(r_acc),
        .rdata_a(bl_at_l), .rdata_b(bl_at_r)
    );

    // Right bank: stores right data XOR the left bank.
    dpram_bank #(.ADDR_W(ADDR_W), .LANES(LANES)) u_bank_r (
        .clk(r_clk), .we(r_we), .wmask(r_mask), .waddr(r_acc),
        .wdata(r_wd ^ bl_at_r), .raddr_a(l_acc), .raddr_b(r_acc),
        .rdata_a(br_at_l), .rdata_b(br_at_r)
    );
endmodule

// File: tb/dpram_burst_top_bench.sv
module dpram_burst_top_bench;
    localparam int CLK_P = 10;
    localparam int AW    = 11;

    typedef struct packed {
        logic          sel;
        logic          wr_n;
        logic          oe_n;
        logic [1:0]    lane_n;
        logic          zero_n;
        logic          load_n;
        logic          step_n;
        logic [AW-1:0] addr;
        logic [15:0]   wdata;
        logic          exp_v;
        logic [15:0]   exp_d;
    } vec_t;

    // Left port, flow-through; expected values sampled one cycle after drive.
    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 11'd5, 16'hA5A5, 1'b0, 16'h0000}, // R1 write 5
        '{1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 11'd0, 16'h1234, 1'b0, 16'h0000}, // R6 step to 6
        '{1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 11'd0, 16'h0F0F, 1'b0, 16'h0000}, // R6 step to 7
        '{1'b1, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 1'b1, 11'd7, 16'hBBCC, 1'b0, 16'h0000}, // R4 low lane only
        '{1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 11'd5, 16'h0000, 1'b1, 16'hA5A5}, // R2 read 5
        '{1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 11'd0, 16'h0000, 1'b1, 16'h1234}, // R6 burst 6
        '{1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 11'd0, 16'h0000, 1'b1, 16'h0FCC}, // R4 burst 7
        '{1'b1, 1'b1, 1'b0, 2'b01, 1'b1, 1'b0, 1'b1, 11'd7, 16'h0000, 1'b1, 16'h0F00}, // R4 upper lane read
        '{1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 11'd5, 16'h7777, 1'b0, 16'h0000}, // R6 clear beats load
        '{1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 11'd0, 16'h0000, 1'b1, 16'h7777}, // R6 word 0 written
        '{1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 11'd5, 16'h0000, 1'b1, 16'hA5A5}, // R6 word 5 untouched
        '{1'b1, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 11'd0, 16'h0000, 1'b0, 16'h0000}, // R10 oe off
        '{1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 11'd0, 16'h0000, 1'b1, 16'hA5A5}, // R6 hold
        '{1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 11'd6, 16'hDEAD, 1'b0, 16'h0000}, // R5 write deselected
        '{1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 11'd6, 16'h0000, 1'b1, 16'h1234}, // R5 word 6 kept
        '{1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 11'd7, 16'h0000, 1'b0, 16'h0000}, // R8 load deselected
        '{1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 11'd0, 16'h0000, 1'b1, 16'h0FCC}, // R8 address kept
        '{1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 11'd0, 16'h0000, 1'b1, 16'h7777}  // R6 load beats step
    };

    logic clk = 1'b0;
    logic rst_n;
    logic l_en_a_n, l_en_b, l_wr_n, l_out_en_n, l_load_n, l_step_n, l_zero_n;
    logic r_en_a_n, r_en_b, r_wr_n, r_out_en_n, r_load_n, r_step_n, r_zero_n;
    logic [1:0]    l_lane_n, r_lane_n;
    logic [AW-1:0] l_addr, r_addr;
    logic [15:0]   l_wdata, r_wdata, l_rdata, r_rdata;
    logic          l_rvalid, r_rvalid;
    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    dpram_burst_top #(.ADDR_W(AW), .LANES(2)) u_dpram_burst_top (
        .rst_n(rst_n),
        .l_clk(clk), .l_en_a_n(l_en_a_n), .l_en_b(l_en_b), .l_wr_n(l_wr_n),
        .l_out_en_n(l_out_en_n), .l_lane_n(l_lane_n), .l_load_n(l_load_n),
        .l_step_n(l_step_n), .l_zero_n(l_zero_n), .l_pipe_mode(1'b0),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
        .r_clk(clk), .r_en_a_n(r_en_a_n), .r_en_b(r_en_b), .r_wr_n(r_wr_n),
        .r_out_en_n(r_out_en_n), .r_lane_n(r_lane_n), .r_load_n(r_load_n),
        .r_step_n(r_step_n), .r_zero_n(r_zero_n), .r_pipe_mode(1'b1),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid)
    );

    task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual valid/data=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_l(input vec_t v);
        l_en_a_n = !v.sel; l_en_b = v.sel; l_wr_n = v.wr_n; l_out_en_n = v.oe_n;
        l_lane_n = v.lane_n; l_zero_n = v.zero_n; l_load_n = v.load_n;
        l_step_n = v.step_n; l_addr = v.addr; l_wdata = v.wdata;
    endtask

    task automatic set_r(input logic sel, input logic wr_n, input logic load_n,
                         input logic [AW-1:0] a, input logic [15:0] d);
        r_en_a_n = !sel; r_en_b = sel; r_wr_n = wr_n; r_out_en_n = 1'b0;
        r_lane_n = 2'b00; r_zero_n = 1'b1; r_load_n = load_n; r_step_n = 1'b1;
        r_addr = a; r_wdata = d;
    endtask

    localparam vec_t L_IDLE = '{1'b0, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 11'd0, 16'h0, 1'b0, 16'h0};

    function automatic vec_t lop(input logic wr_n, input logic load_n, input logic step_n,
                                 input logic [AW-1:0] a, input logic [15:0] d);
        return '{1'b1, wr_n, 1'b0, 2'b00, 1'b1, load_n, step_n, a, d, 1'b0, 16'h0};
    endfunction

    initial begin
        #(CLK_P * 5000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        vec_t v;
        rst_n = 1'b0;
        set_l(L_IDLE);
        set_r(1'b0, 1'b1, 1'b1, '0, '0);
        repeat (3) @(negedge clk);
        // R11 outputs quiet in reset
        chk("R11 left", {l_rvalid, l_rdata}, 17'h0);
        chk("R11 right", {r_rvalid, r_rdata}, 17'h0);
        rst_n = 1'b1;

        // Table walk on the left port (flow-through)
        for (int i = 0; i < NV; i++) begin
            set_l(VEC[i]);
            @(negedge clk);
            chk($sformatf("R2/vector %0d", i), {l_rvalid, l_rdata}, {VEC[i].exp_v, VEC[i].exp_d});
        end

        // R5 each enable alone leaves the port deselected
        v = lop(1'b0, 1'b0, 1'b1, 11'd5, 16'h0BAD); v.sel = 1'b0;
        set_l(v); l_en_a_n = 1'b1; l_en_b = 1'b1; @(negedge clk);
        set_l(v); l_en_a_n = 1'b0; l_en_b = 1'b0; @(negedge clk);
        set_l(lop(1'b1, 1'b0, 1'b1, 11'd5, 16'h0)); @(negedge clk);
        chk("R5 single enable", {l_rvalid, l_rdata}, {1'b1, 16'hA5A5});

        // R7 counter wraps from the top address to 0
        set_l(lop(1'b0, 1'b0, 1'b1, 11'h7FF, 16'h1111)); @(negedge clk);
        set_l(lop(1'b0, 1'b1, 1'b0, 11'd0, 16'h2222)); @(negedge clk);
        set_l(lop(1'b1, 1'b0, 1'b1, 11'd0, 16'h0)); @(negedge clk);
        chk("R7 wrap", {l_rvalid, l_rdata}, {1'b1, 16'h2222});
        set_l(lop(1'b1, 1'b0, 1'b1, 11'h7FF, 16'h0)); @(negedge clk);
        chk("R7 top word", {l_rvalid, l_rdata}, {1'b1, 16'h1111});

        // R1 right writes, left reads
        set_l(L_IDLE);
        set_r(1'b1, 1'b0, 1'b0, 11'd9, 16'h4321); @(negedge clk);
        set_r(1'b0, 1'b1, 1'b1, '0, '0);
        set_l(lop(1'b1, 1'b0, 1'b1, 11'd9, 16'h0)); @(negedge clk);
        chk("R1 cross port", {l_rvalid, l_rdata}, {1'b1, 16'h4321});

        // R3 pipelined right read arrives one clock later
        set_l(L_IDLE);
        set_r(1'b1, 1'b1, 1'b0, 11'd5, 16'h0); @(negedge clk);
        chk("R3 not yet", {r_rvalid, r_rdata}, 17'h0);
        set_r(1'b0, 1'b1, 1'b1, '0, '0); @(negedge clk);
        chk("R3 delayed", {r_rvalid, r_rdata}, {1'b1, 16'hA5A5});

        // R9 same-cycle write left / read right of word 6
        set_l(lop(1'b0, 1'b0, 1'b1, 11'd6, 16'h9999));
        set_r(1'b1, 1'b1, 1'b0, 11'd6, 16'h0); @(negedge clk);
        set_l(L_IDLE);
        set_r(1'b1, 1'b1, 1'b1, 11'd0, 16'h0); @(negedge clk);
        chk("R9 old data", {r_rvalid, r_rdata}, {1'b1, 16'h1234});
        @(negedge clk);
        chk("R9 new data", {r_rvalid, r_rdata}, {1'b1, 16'h9999});

        // R11 reset clears the counter; memory keeps its contents
        set_r(1'b0, 1'b1, 1'b1, '0, '0);
        set_l(lop(1'b1, 1'b0, 1'b1, 11'd5, 16'h0)); @(negedge clk);
        rst_n = 1'b0; set_l(L_IDLE); @(negedge clk);
        rst_n = 1'b1;
        set_l(lop(1'b1, 1'b1, 1'b1, 11'd3, 16'h0)); @(negedge clk);
        chk("R11 counter cleared", {l_rvalid, l_rdata}, {1'b1, 16'h2222});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule